// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external host reach a bank of byte-wide control registers over a four-wire serial link. It acts as a full-duplex slave. The host lowers chip select and sends an address byte, then one, two or three data bytes. The first byte carries a 7-bit register address and a direction flag. While the host clocks its bytes in, the slave sends back the current contents of each register the frame addresses. Frames of three or four bytes step through consecutive addresses starting at the one given.

The serial pins are brought into the system clock domain through synchronizers, and all edge detection happens there. Writes are held in a small buffer and sent to the register bus only once chip select has returned high and the frame length has been found legal. A latched failure flag records three faults: a bad frame length, a write to a locked register, and an illegal operating-mode code. The flag is cleared by a write-one-to-clear access. Frames longer than 32 bits turn the output into an echo of the input. A sleep input shuts the whole interface off.

Top module: `spi_reg_slave`

## Requirements
- R1: SDI is sampled on a falling SCK edge, and SDO changes only after a rising SCK edge. Bits travel most-significant first. Chip select is active low, and its falling edge restarts the frame.
- R2: In the first byte, bits 7:1 are the register address and bit 0 is the direction (0 = write, 1 = read). In a 16-bit write frame, the second byte is stored at that address.
- R3: A frame with direction bit 1 changes no register, whatever SDI carries after the direction bit.
- R4: A 24-bit frame covers the base address and base+1. A 32-bit frame covers base, base+1 and base+2. Data bytes go to these addresses in the order they were sent.
- R5: SDO is 0 during the address byte. During data byte k (k = 0, 1, 2), SDO carries the value that address base+k held before the frame. An address at or above NUM_REGS reads as 0, except address 0x7F, which returns the failure flag in bit 0.
- R6: A frame whose bit count is not exactly 16, 24 or 32 writes nothing. If failure detection is enabled, it sets the failure flag.
- R7: A data byte whose target address is at or above NUM_REGS is dropped without a bus write and without a failure.
- R8: A data byte aimed at a register whose lock input is high is dropped. If detection is enabled, it sets the failure flag.
- R9: A byte written to the mode register (address 0x01) is dropped if its code in bits 2:0 is 4 to 7. If detection is enabled, it sets the failure flag. Codes 0 to 3 are written normally.
- R10: The failure flag is 0 after reset and stays set until a write frame delivers a byte with bit 0 high to address 0x7F. It never sets while detection is disabled.
- R11: When a frame runs past 32 bits, the SDO bit sent for bit position n (counting from 0, for n of 33 or more) equals the SDI bit sampled at position n-1.
- R12: While the sleep input is high, SDO stays 0, and no write or failure results from any frame activity.
- R13: Register bus writes occur only while chip select is high, with at most one write per clock cycle. A legal write frame produces exactly one write per data byte it delivers in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | High disables all serial activity |
| fail_det_en_i | input | 1 | Enables latching of failures |
| spi_sck_i | input | 1 | Serial clock from host |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_sdi_i | input | 1 | Serial data in |
| spi_sdo_o | output | 1 | Serial data out |
| rd_addr_o | output | 7 | Register read address |
| rd_data_i | input | 8 | Register read data, combinational from rd_addr_o |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 7 | Register write address |
| wr_data_o | output | 8 | Register write data |
| lock_i | input | NUM_REGS | Per-register write lock |
| fail_flag_o | output | 1 | Latched failure flag |

## Verification
Each pin change passes two synchronizer stages before an edge is seen, so SDO settles on the third clock after a rising SCK edge. The bench reads SDO just before it drives the next falling edge, eight clocks after the rise. Committed writes reach the bus between the fifth and seventh clock after chip select rises, and the failure flag settles in the same window. The bench therefore waits twelve clocks after every frame before it compares the register bank and the flag with its own model.

// File: rtl/spi_reg_pkg.sv
// Package: constants and types shared by the serial register-access slave.
// Assumes byte-wide registers with 7-bit addresses, as fixed by the frame layout.
package spi_reg_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int CNT_W    = 6;
    localparam int MAX_DATA = 3;

    localparam logic [CNT_W-1:0] CNT_SAT = '1;
    localparam logic [CNT_W-1:0] CNT_B1  = 6'd8;
    localparam logic [CNT_W-1:0] CNT_B2  = 6'd16;
    localparam logic [CNT_W-1:0] CNT_B3  = 6'd24;
    localparam logic [CNT_W-1:0] CNT_B4  = 6'd32;

    typedef logic [BYTE_W-1:0] byte_t;

    // Snapshot of a finished frame handed from the shifter to the commit unit
    typedef struct packed {
        logic                       rd;
        logic [ADDR_W:0]            base;
        logic [CNT_W-1:0]           nbits;
        byte_t [MAX_DATA-1:0]       data;
    } frame_t;

    // True when a bit count is one of the three legal frame lengths
    function automatic logic len_legal(input logic [CNT_W-1:0] n);
        return (n == CNT_B2) || (n == CNT_B3) || (n == CNT_B4);
    endfunction
endpackage

// File: rtl/spi_in_sync.sv
// Module: multi-stage synchronizer for the asynchronous serial pins.
// Assumes the pins change slowly compared with clk; each bit is synchronized
// on its own, with no relation kept between bits.
module spi_in_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= async_i;
                end
            end else begin : g_next
                // Later stages shift the sample along
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
// Module: serial frame engine. It detects SCK and chip-select edges on the
// synchronized pins, counts bits, captures the address byte and data bytes,
// steps the read pointer, and drives SDO with read data or the echo.
// Assumes rd_val_i is a combinational function of rd_ptr_o and is stable
// by the next SCK rising edge.
module spi_frame_shifter
    import spi_reg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             sck_s,
    input  logic             csn_s,
    input  logic             sdi_s,
    input  byte_t            rd_val_i,
    output logic [ADDR_W:0]  rd_ptr_o,
    output logic             sdo_o,
    output frame_t           frame_o,
    output logic             frame_done_o
);
    logic                  sck_q, csn_q, in_frame, last_sdi, rd_q;
    logic [CNT_W-1:0]      cnt;
    logic [BYTE_W-2:0]     shin;
    byte_t                 tx_sh;
    logic [ADDR_W:0]       base_q;
    byte_t [MAX_DATA-1:0]  data_q;

    logic                  sck_fall, sck_rise, cs_fall, cs_rise;
    logic [CNT_W-1:0]      cnt_next;
    byte_t                 byte_now;

    // Edge flags and the next bit count
    always_comb begin
        sck_fall = sck_q & ~sck_s;
        sck_rise = ~sck_q & sck_s;
        cs_fall  = csn_q & ~csn_s;
        cs_rise  = ~csn_q & csn_s;
        cnt_next = (cnt == CNT_SAT) ? cnt : cnt + 1'b1;
        byte_now = {shin, sdi_s};
    end

    // Frame state: bit count, shift-in, capture and SDO drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q        <= 1'b1;
            csn_q        <= 1'b1;
            in_frame     <= 1'b0;
            cnt          <= '0;
            shin         <= '0;
            tx_sh        <= '0;
            last_sdi     <= 1'b0;
            rd_q         <= 1'b0;
            base_q       <= '0;
            rd_ptr_o     <= '0;
            data_q       <= '0;
            sdo_o        <= 1'b0;
            frame_done_o <= 1'b0;
        end else begin
            sck_q        <= sck_s;
            csn_q        <= csn_s;
            frame_done_o <= 1'b0;
            if (sleep_i) begin
                in_frame <= 1'b0;
                sdo_o    <= 1'b0;
            end else if (cs_fall) begin
                in_frame <= 1'b1;
                cnt      <= '0;
                tx_sh    <= '0;
                sdo_o    <= 1'b0;
            end else if (in_frame) begin
                if (cs_rise) begin
                    in_frame     <= 1'b0;
                    frame_done_o <= 1'b1;
                    sdo_o        <= 1'b0;
                end else begin
                    if (sck_fall) begin
                        cnt      <= cnt_next;
                        shin     <= byte_now[BYTE_W-2:0];
                        last_sdi <= sdi_s;
                        case (cnt_next)
                            CNT_B1: begin
                                base_q   <= {1'b0, byte_now[BYTE_W-1:1]};
                                rd_q     <= byte_now[0];
                                rd_ptr_o <= {1'b0, byte_now[BYTE_W-1:1]};
                            end
                            CNT_B2: begin
                                data_q[0] <= byte_now;
                                rd_ptr_o  <= rd_ptr_o + 1'b1;
                            end
                            CNT_B3: begin
                                data_q[1] <= byte_now;
                                rd_ptr_o  <= rd_ptr_o + 1'b1;
                            end
                            CNT_B4:  data_q[2] <= byte_now;
                            default: ;
                        endcase
                    end
                    if (sck_rise) begin
                        if ((cnt == CNT_B1) || (cnt == CNT_B2) || (cnt == CNT_B3)) begin
                            {sdo_o, tx_sh} <= {rd_val_i, 1'b0};
                        end else if (cnt > CNT_B4) begin
                            sdo_o <= last_sdi;
                        end else begin
                            {sdo_o, tx_sh} <= {tx_sh, 1'b0};
                        end
                    end
                end
            end
        end
    end

    assign frame_o = '{rd: rd_q, base: base_q, nbits: cnt, data: data_q};
endmodule

// File: rtl/spi_commit_unit.sv
// Module: write commit and failure latch. After a finished frame it checks
// the length, then plays the buffered bytes onto the register bus one per
// cycle, dropping out-of-range, locked or illegal-mode bytes, and keeps the
// sticky failure flag with its write-one-to-clear address.
// Assumes lock_i is steady while a commit is in progress.
module spi_commit_unit
    import spi_reg_pkg::*;
#(
    parameter int                 NUM_REGS   = 32,
    parameter logic [ADDR_W-1:0]  MODE_ADDR  = 7'h01,
    parameter logic [7:0]         MODE_LEGAL = 8'h0F,
    parameter logic [ADDR_W-1:0]  FAIL_ADDR  = 7'h7F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  frame_t               frame_i,
    input  logic                 frame_done_i,
    input  logic                 fail_en_i,
    input  logic [NUM_REGS-1:0]  lock_i,
    output logic                 wr_en_o,
    output logic [ADDR_W-1:0]    wr_addr_o,
    output byte_t                wr_data_o,
    output logic                 fail_flag_o
);
    localparam int              IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W:0] NUM_L = (ADDR_W+1)'(NUM_REGS);

    logic                  busy;
    logic [1:0]            left, idx;
    logic [ADDR_W:0]       ptr;
    byte_t [MAX_DATA-1:0]  buf_q;

    byte_t                 cur;
    logic                  in_rng, locked, mode_bad, do_wr, clr_hit, byte_err, len_err;

    // Per-byte decision for the byte now at the head of the commit
    always_comb begin
        cur      = buf_q[idx];
        in_rng   = ptr < NUM_L;
        locked   = in_rng && lock_i[ptr[IDX_W-1:0]];
        mode_bad = in_rng && (ptr == {1'b0, MODE_ADDR}) && !MODE_LEGAL[cur[2:0]];
        do_wr    = busy && in_rng && !locked && !mode_bad;
        byte_err = busy && (locked || mode_bad);
        clr_hit  = busy && (ptr == {1'b0, FAIL_ADDR}) && cur[0];
        len_err  = frame_done_i && !len_legal(frame_i.nbits);
    end

    // Commit sequencer: loads a finished write frame and walks its bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            left  <= '0;
            idx   <= '0;
            ptr   <= '0;
            buf_q <= '0;
        end else if (frame_done_i) begin
            busy  <= len_legal(frame_i.nbits) && !frame_i.rd;
            ptr   <= frame_i.base;
            idx   <= '0;
            buf_q <= frame_i.data;
            case (frame_i.nbits)
                CNT_B2:  left <= 2'd1;
                CNT_B3:  left <= 2'd2;
                default: left <= 2'd3;
            endcase
        end else if (busy) begin
            ptr  <= ptr + 1'b1;
            idx  <= idx + 1'b1;
            left <= left - 1'b1;
            if (left == 2'd1) busy <= 1'b0;
        end
    end

    // Register-bus write port, registered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o   <= do_wr;
            wr_addr_o <= ptr[ADDR_W-1:0];
            wr_data_o <= cur;
        end
    end

    // Sticky failure flag: setting has priority over clearing
    always_ff @(posedge clk) begin
        if (!rst_n)                               fail_flag_o <= 1'b0;
        else if ((len_err || byte_err) && fail_en_i) fail_flag_o <= 1'b1;
        else if (clr_hit)                         fail_flag_o <= 1'b0;
    end
endmodule

// File: rtl/spi_reg_slave.sv
// Module: top of the serial register-access slave. It synchronizes the
// pins, runs the frame engine, selects the read value returned on SDO and
// hands finished frames to the commit unit.
// Assumes the register map answers rd_addr_o combinationally on rd_data_i.
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int                 NUM_REGS    = 32,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0]  MODE_ADDR   = 7'h01,
    parameter logic [7:0]         MODE_LEGAL  = 8'h0F,
    parameter logic [ADDR_W-1:0]  FAIL_ADDR   = 7'h7F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_i,
    input  logic                 fail_det_en_i,
    input  logic                 spi_sck_i,
    input  logic                 spi_csn_i,
    input  logic                 spi_sdi_i,
    output logic                 spi_sdo_o,
    output logic [ADDR_W-1:0]    rd_addr_o,
    input  logic [BYTE_W-1:0]    rd_data_i,
    output logic                 wr_en_o,
    output logic [ADDR_W-1:0]    wr_addr_o,
    output logic [BYTE_W-1:0]    wr_data_o,
    input  logic [NUM_REGS-1:0]  lock_i,
    output logic                 fail_flag_o
);
    localparam logic [ADDR_W:0] NUM_L = (ADDR_W+1)'(NUM_REGS);

    logic [2:0]       pins_s;
    logic             sck_s, csn_s, sdi_s;
    logic [ADDR_W:0]  rd_ptr;
    byte_t            rd_val;
    frame_t           frame;
    logic             frame_done;

    spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_sck_i, spi_csn_i, spi_sdi_i}),
        .sync_o  (pins_s)
    );

    assign {sck_s, csn_s, sdi_s} = pins_s;
    assign rd_addr_o             = rd_ptr[ADDR_W-1:0];

    // Value returned on SDO for the address under the read pointer
    always_comb begin
        if (rd_ptr < NUM_L)                       rd_val = rd_data_i;
        else if (rd_ptr == {1'b0, FAIL_ADDR})     rd_val = {7'b0, fail_flag_o};
        else                                      rd_val = '0;
    end

    spi_frame_shifter i_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_i      (sleep_i),
        .sck_s        (sck_s),
        .csn_s        (csn_s),
        .sdi_s        (sdi_s),
        .rd_val_i     (rd_val),
        .rd_ptr_o     (rd_ptr),
        .sdo_o        (spi_sdo_o),
        .frame_o      (frame),
        .frame_done_o (frame_done)
    );

    spi_commit_unit #(
        .NUM_REGS   (NUM_REGS),
        .MODE_ADDR  (MODE_ADDR),
        .MODE_LEGAL (MODE_LEGAL),
        .FAIL_ADDR  (FAIL_ADDR)
    ) i_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_i      (frame),
        .frame_done_i (frame_done),
        .fail_en_i    (fail_det_en_i),
        .lock_i       (lock_i),
        .wr_en_o      (wr_en_o),
        .wr_addr_o    (wr_addr_o),
        .wr_data_o    (wr_data_o),
        .fail_flag_o  (fail_flag_o)
    );
endmodule

// File: rtl/spi_reg_slave_chk.sv
// Module: property checker for the serial register-access slave, bound
// onto every instance of the top module.
module spi_reg_slave_chk #(
    parameter int          NUM_REGS   = 32,
    parameter logic [6:0]  MODE_ADDR  = 7'h01,
    parameter logic [7:0]  MODE_LEGAL = 8'h0F
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sleep_i,
    input logic                 fail_det_en_i,
    input logic                 spi_sdo_o,
    input logic                 wr_en_o,
    input logic [6:0]           wr_addr_o,
    input logic [7:0]           wr_data_o,
    input logic [NUM_REGS-1:0]  lock_i,
    input logic                 fail_flag_o,
    input logic                 csn_s
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    AST_WR_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> csn_s);                                            // R13
    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (int'(wr_addr_o) < NUM_REGS));                     // R7
    AST_WR_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !lock_i[wr_addr_o[IDX_W-1:0]]);                    // R8
    AST_MODE_CODE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && (wr_addr_o == MODE_ADDR)) |-> MODE_LEGAL[wr_data_o[2:0]]); // R9
    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_flag_o) |-> $past(fail_det_en_i));                  // R10
    AST_SDO_QUIET_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && $past(sleep_i)) |-> !spi_sdo_o);                   // R12
endmodule

bind spi_reg_slave spi_reg_slave_chk #(
    .NUM_REGS   (NUM_REGS),
    .MODE_ADDR  (MODE_ADDR),
    .MODE_LEGAL (MODE_LEGAL)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_i       (sleep_i),
    .fail_det_en_i (fail_det_en_i),
    .spi_sdo_o     (spi_sdo_o),
    .wr_en_o       (wr_en_o),
    .wr_addr_o     (wr_addr_o),
    .wr_data_o     (wr_data_o),
    .lock_i        (lock_i),
    .fail_flag_o   (fail_flag_o),
    .csn_s         (csn_s)
);

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
    localparam int NR = 32;
    localparam int H  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep = 1'b0, fail_en = 1'b1;
    logic          sck = 1'b1, csn = 1'b1, sdi = 1'b0;
    logic          sdo, wr_en, flag;
    logic [6:0]    rd_addr, wr_addr;
    logic [7:0]    rd_data, wr_data;
    logic [NR-1:0] lock = '0;

    logic [7:0] mem   [NR];
    logic [7:0] model [NR];
    logic       model_flag = 1'b0;
    int         total = 0, passed = 0;
    int         wr_seen = 0, bad_wr = 0;

    always #5 clk = ~clk;

    spi_reg_slave i_spi_reg_slave (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .fail_det_en_i(fail_en),
        .spi_sck_i(sck), .spi_csn_i(csn), .spi_sdi_i(sdi), .spi_sdo_o(sdo),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data), .wr_en_o(wr_en),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .lock_i(lock), .fail_flag_o(flag)
    );

    // Register map model on the bus side
    assign rd_data = (rd_addr < 7'd32) ? mem[rd_addr[4:0]] : 8'h00;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) mem[i] <= 8'(i * 13 + 5);
        end else if (wr_en && wr_addr < 7'd32) begin
            mem[wr_addr[4:0]] <= wr_data;
        end
    end

    // Write counters for R13
    always @(posedge clk) begin
        if (rst_n && wr_en) begin
            wr_seen = wr_seen + 1;
            if (!csn) bad_wr = bad_wr + 1;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total = total + 1;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (ok) passed = passed + 1;
        else $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    endtask

    function automatic logic [7:0] rdval(input int a);
        if (a < NR)    return model[a];
        if (a == 127)  return {7'b0, model_flag};
        return 8'h00;
    endfunction

    // Expected SDO stream and register/flag update, from the requirements
    task automatic model_frame(input int nbits, input logic [63:0] tx,
                               output logic [63:0] erx);
        int base; logic rd; logic [7:0] d; int a;
        erx = '0;
        if (sleep) return;                                   // R12
        base = int'(tx[63:57]);
        rd   = tx[56];
        for (int k = 0; k < 3; k++) begin                    // R5
            d = rdval(base + k);
            for (int j = 0; j < 8; j++)
                if (8*(k+1) + j < nbits) erx[63 - 8*(k+1) - j] = d[7-j];
        end
        for (int i = 33; i < nbits; i++) erx[63-i] = tx[64-i]; // R11
        if (!(nbits == 16 || nbits == 24 || nbits == 32)) begin
            if (fail_en) model_flag = 1'b1;                  // R6
        end else if (!rd) begin
            for (int k = 0; k < nbits/8 - 1; k++) begin
                a = base + k;
                d = tx[55 - 8*k -: 8];
                if (a < NR) begin
                    if (lock[a] || (a == 1 && d[2:0] >= 3'd4)) begin
                        if (fail_en) model_flag = 1'b1;      // R8 R9
                    end else model[a] = d;
                end else if (a == 127 && d[0]) model_flag = 1'b0; // R10
            end
        end
    endtask

    task automatic run_frame(input int nbits, input logic [63:0] tx,
                             output logic [63:0] rx);
        rx = '0;
        @(negedge clk); csn = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rx[63-i] = sdo;
            sdi = tx[63-i]; sck = 1'b0;
            repeat (H) @(negedge clk);
            sck = 1'b1;
            repeat (H) @(negedge clk);
        end
        csn = 1'b0; csn = 1'b1; sdi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic do_frame(input int nbits, input logic [63:0] tx, input string req);
        logic [63:0] erx, rx; int bad;
        model_frame(nbits, tx, erx);
        run_frame(nbits, tx, rx);
        chk(rx == erx, req, "sdo stream", rx, erx);
        bad = -1;
        for (int i = 0; i < NR; i++) if (bad < 0 && mem[i] !== model[i]) bad = i;
        chk(bad < 0, req, "register bank", (bad < 0) ? 64'h0 : 64'(mem[bad]),
            (bad < 0) ? 64'h0 : 64'(model[bad]));
        chk(flag === model_flag, req, "fail flag", 64'(flag), 64'(model_flag));
    endtask

    function automatic logic [63:0] mk(input int addr, input bit rd,
                                       input logic [7:0] d0, d1, d2, x);
        return {7'(addr), rd, d0, d1, d2, x, 24'h0};
    endfunction

    initial begin
        int nb, w0;
        void'($urandom(32'd7321));
        for (int i = 0; i < NR; i++) model[i] = 8'(i * 13 + 5);
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sdo === 1'b0, "R1", "sdo after reset", 64'(sdo), 64'h0);
        chk(flag === 1'b0, "R10", "flag after reset", 64'(flag), 64'h0);
        chk(wr_en === 1'b0, "R13", "no write after reset", 64'(wr_en), 64'h0);

        do_frame(16, mk(3, 0, 8'hA5, 0, 0, 0), "R2");
        do_frame(16, mk(3, 1, 8'h3C, 0, 0, 0), "R3");
        do_frame(24, mk(5, 0, 8'h11, 8'h22, 0, 0), "R4");
        do_frame(32, mk(4, 1, 8'hFF, 8'hFF, 8'hFF, 0), "R5");
        w0 = wr_seen;
        do_frame(32, mk(30, 0, 8'h9A, 8'hBC, 8'hDE, 0), "R7");
        chk(wr_seen - w0 == 2, "R13", "writes for 30..32", 64'(wr_seen - w0), 64'd2);
        do_frame(20, mk(2, 0, 8'h77, 8'h70, 0, 0), "R6");
        do_frame(16, mk(127, 1, 0, 0, 0, 0), "R5");
        do_frame(16, mk(127, 0, 8'h01, 0, 0, 0), "R10");
        lock[7] = 1'b1;
        do_frame(24, mk(6, 0, 8'h44, 8'h55, 0, 0), "R8");
        lock[7] = 1'b0;
        do_frame(16, mk(127, 0, 8'h01, 0, 0, 0), "R10");
        do_frame(16, mk(1, 0, 8'h05, 0, 0, 0), "R9");
        do_frame(16, mk(127, 0, 8'h01, 0, 0, 0), "R10");
        do_frame(16, mk(1, 0, 8'h02, 0, 0, 0), "R9");
        fail_en = 1'b0;
        do_frame(12, mk(8, 0, 8'h12, 0, 0, 0), "R10");
        fail_en = 1'b1;
        do_frame(40, mk(9, 0, 8'h5A, 8'hC3, 8'h96, 8'hE1), "R11");
        do_frame(16, mk(127, 0, 8'h01, 0, 0, 0), "R10");
        sleep = 1'b1;
        repeat (3) @(negedge clk);
        do_frame(16, mk(10, 0, 8'hEE, 0, 0, 0), "R12");
        do_frame(20, mk(11, 0, 8'hEE, 0, 0, 0), "R12");
        sleep = 1'b0;
        repeat (3) @(negedge clk);

        for (int it = 0; it < 40; it++) begin
            case ($urandom % 8)
                0:       nb = 17 + int'($urandom % 15);
                1, 2:    nb = 16;
                3, 4:    nb = 24;
                default: nb = 32;
            endcase
            lock = ($urandom % 4 == 0) ? (32'd1 << ($urandom % 32)) : '0;
            do_frame(nb, mk(int'($urandom % 36), 1'($urandom), 8'($urandom),
                            8'($urandom), 8'($urandom), 0), "R1");
            if (flag) begin
                lock = '0;
                do_frame(16, mk(127, 0, 8'h01, 0, 0, 0), "R10");
            end
        end
        chk(bad_wr == 0, "R13", "writes with chip select low", 64'(bad_wr), 64'h0);
        summary();
    end
endmodule